// File: doc/BRIEF.md
# Receive Frame Page Writer

The block takes one received frame at a time and lays it out in a packet page of shared buffer RAM, one byte per clock. A frame is announced on a descriptor handshake that carries its length in bytes; the frame's bytes then follow on a separate byte stream. The block first sizes the frame. It then asks an external page allocator for a page and writes the page in this order: a little-endian status word, a little-endian byte count, the frame data, zero fill up to the minimum frame length, an optional four-byte CRC supplied by a separate CRC unit, and a closing pair made of a data byte and a control byte. When the control byte has been written, the block pushes the page number to the receive queue and raises the receive interrupt.

A frame can be refused in three cases: receive is disabled, soft reset is held, or the page would overflow. It is also refused when the allocator has no free page. A refused frame's bytes are still taken from the stream and thrown away, so the next frame stays aligned. Both input interfaces use valid/ready. The descriptor is accepted only while the block is idle. A stream byte moves only in a cycle where both in_valid and in_ready are high. The source may hold or withdraw in_valid at any time without losing data. in_ready is high only while the block needs a byte. The configuration pins and the CRC value are sampled as plain levels. The configuration is captured when the descriptor is accepted.

Top module: `rx_frame_formatter`

## Requirements
- R1: A frame accepted while cfg_rx_en is 0 or cfg_soft_rst is 1 is refused: a one-cycle refused pulse in the accept cycle, no alloc_req, no RAM write, and exactly frm_len stream bytes consumed and discarded.
- R2: The byte count is the body size plus 6, plus 4 when cfg_strip_crc is 0. The body size is 64 for frames shorter than 64 bytes and otherwise the length rounded down to even. A frame whose count would exceed 2048 is refused and drained as in R1.
- R3: Page bytes 0 and 1 hold the status word (low byte first), and bytes 2 and 3 hold the byte count (low byte first).
- R4: Status bit 11 is set when the length exceeds 1518, and status bit 12 is set when the length is odd. All other status bits are 0.
- R5: Frame bytes are written in arrival order from page byte 4. A frame shorter than 64 bytes, including its odd last byte, is followed by zero bytes up to 64 body bytes. A frame of 64 bytes or more has only its even part in the body.
- R6: When cfg_strip_crc is 0, the four bytes of crc_in follow the body, least significant byte first. When it is 1, no CRC bytes are written.
- R7: The closing pair is the held-back odd last byte followed by 0x60 for odd frames of 64 bytes or more. For all other frames, including padded odd ones, it is 0x00 followed by 0x40.
- R8: An accepted frame raises alloc_req until alloc_ack. If alloc_ok is 1, every write goes to alloc_page. If alloc_ok is 0, the frame is refused and drained.
- R9: In the cycle after the control byte is written, done, rxq_push and rcv_irq pulse together for one cycle, with rxq_page equal to the page written.
- R10: Writes of one frame go to consecutive addresses. With no stream stall, the control byte is written byte-count minus 1 cycles after status byte 0, so one byte is written per clock.
- R11: in_ready is never high while frm_ready is high. Stream stalls lose or duplicate no byte. A frame never consumes more than frm_len bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_soft_rst | input | 1 | Soft reset held; frames refused |
| cfg_strip_crc | input | 1 | 1: do not store CRC bytes |
| frm_valid | input | 1 | Frame descriptor valid |
| frm_ready | output | 1 | Descriptor accepted (idle) |
| frm_len | input | LEN_W | Frame length in bytes |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block takes a byte this cycle |
| in_data | input | 8 | Stream byte |
| crc_in | input | 32 | CRC of the frame, stable through the frame |
| alloc_req | output | 1 | Page request |
| alloc_ack | input | 1 | Allocator answer this cycle |
| alloc_ok | input | 1 | Page granted (else none free) |
| alloc_page | input | PAGE_W | Granted page number |
| wr_en | output | 1 | RAM write strobe |
| wr_page | output | PAGE_W | RAM write page |
| wr_addr | output | ADDR_W | Byte offset inside the page |
| wr_data | output | 8 | RAM write byte |
| done | output | 1 | Frame stored |
| rxq_push | output | 1 | Push to receive queue |
| rxq_page | output | PAGE_W | Page pushed |
| rcv_irq | output | 1 | Receive interrupt set pulse |
| refused | output | 1 | Frame refused pulse |

## Verification
The assertions assume that alloc_ack arrives only while alloc_req is high, that crc_in stays constant from descriptor to done, and that the byte stream carries exactly frm_len bytes per frame. The stimulus sends one frame at a time, queues exactly the announced bytes and holds the CRC value per frame. Its allocator answers only an active request, sometimes after random delay cycles. Stream stalls are inserted at random on selected frames. The cycle count for one byte per clock is checked only on stall-free frames.

// File: rtl/rx_fmt_pkg.sv
package rx_fmt_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DRAIN, S_ALLOC, S_HDR, S_BODY, S_CRC, S_TRL0, S_TRL1, S_FIN
  } fmt_state_t;

  // sizing decision for one frame, fields are header-word wide
  typedef struct packed {
    logic [15:0] status;
    logic [15:0] count;
    logic [15:0] body;
    logic        odd_long;
    logic        keep_crc;
    logic        refuse;
  } fmt_plan_t;

endpackage

// File: rtl/rx_fmt_plan.sv
module rx_fmt_plan
  import rx_fmt_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int MIN_FRAME  = 64,
  parameter int PAGE_BYTES = 2048,
  parameter int LONG_LIMIT = 1518
) (
  input  logic [LEN_W-1:0] len,
  input  logic             rx_en,
  input  logic             soft_rst,
  input  logic             strip_crc,
  output fmt_plan_t        plan
);
  localparam int HDR_TRL_BYTES = 6;
  localparam int CRC_BYTES     = 4;

  logic [15:0] len16, even_len, body;
  logic [16:0] total;
  logic        is_short;

  always_comb begin
    len16    = 16'(len);
    even_len = {len16[15:1], 1'b0};
    is_short = len16 < 16'(MIN_FRAME);
    body     = is_short ? 16'(MIN_FRAME) : even_len;
    total    = 17'(body) + 17'(HDR_TRL_BYTES) + (strip_crc ? 17'd0 : 17'(CRC_BYTES));

    plan.status   = {3'b000, len16[0], (len16 > 16'(LONG_LIMIT)), 11'd0};
    plan.count    = total[15:0];
    plan.body     = body;
    plan.odd_long = len16[0] && !is_short;
    plan.keep_crc = !strip_crc;
    plan.refuse   = !rx_en || soft_rst || (total > 17'(PAGE_BYTES));
  end

endmodule

// File: rtl/rx_fmt_engine.sv
module rx_fmt_engine
  import rx_fmt_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int PAGE_W = 2,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  fmt_plan_t         plan,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [31:0]       crc_in,
  output logic              alloc_req,
  input  logic              alloc_ack,
  input  logic              alloc_ok,
  input  logic [PAGE_W-1:0] alloc_page,
  output logic              wr_en,
  output logic [PAGE_W-1:0] wr_page,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic              refused
);
  localparam int IDX_W = 16;
  localparam logic [7:0] CTRL_ODD  = 8'h60;
  localparam logic [7:0] CTRL_EVEN = 8'h40;

  fmt_state_t        st_q, st_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [15:0]       status_q, status_d, count_q, count_d, body_q, body_d;
  logic              oddl_q, oddl_d, keep_q, keep_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        last_q, last_d;
  logic              have_q, have_d;
  logic              need_byte;

  always_comb begin
    st_d = st_q;     len_d = len_q;     idx_d = idx_q;
    status_d = status_q; count_d = count_q; body_d = body_q;
    oddl_d = oddl_q; keep_d = keep_q;   page_d = page_q;
    addr_d = addr_q; last_d = last_q;   have_d = have_q;
    frm_ready = 1'b0; in_ready = 1'b0; alloc_req = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00; done = 1'b0; refused = 1'b0;
    need_byte = 1'b0;

    case (st_q)
      S_IDLE: begin
        frm_ready = 1'b1;
        if (frm_valid) begin
          len_d    = frm_len;
          status_d = plan.status;
          count_d  = plan.count;
          body_d   = plan.body;
          oddl_d   = plan.odd_long;
          keep_d   = plan.keep_crc;
          if (plan.refuse) begin
            refused = 1'b1;
            idx_d   = IDX_W'(frm_len);
            st_d    = (frm_len != '0) ? S_DRAIN : S_IDLE;
          end else begin
            st_d = S_ALLOC;
          end
        end
      end
      S_DRAIN: begin
        in_ready = 1'b1;
        if (in_valid) begin
          idx_d = idx_q - 1'b1;
          if (idx_q == IDX_W'(1)) st_d = S_IDLE;
        end
      end
      S_ALLOC: begin
        alloc_req = 1'b1;
        if (alloc_ack) begin
          if (alloc_ok) begin
            page_d = alloc_page;
            addr_d = '0;
            idx_d  = '0;
            have_d = 1'b0;
            st_d   = S_HDR;
          end else begin
            refused = 1'b1;
            idx_d   = IDX_W'(len_q);
            st_d    = (len_q != '0) ? S_DRAIN : S_IDLE;
          end
        end
      end
      S_HDR: begin
        wr_en = 1'b1;
        case (idx_q[1:0])
          2'd0:    wr_data = status_q[7:0];
          2'd1:    wr_data = status_q[15:8];
          2'd2:    wr_data = count_q[7:0];
          default: wr_data = count_q[15:8];
        endcase
        idx_d = idx_q + 1'b1;
        if (idx_q[1:0] == 2'd3) begin
          idx_d = '0;
          st_d  = S_BODY;
        end
      end
      S_BODY: begin
        need_byte = idx_q < IDX_W'(len_q);
        in_ready  = need_byte;
        wr_en     = need_byte ? in_valid : 1'b1;
        wr_data   = need_byte ? in_data : 8'h00;
        if (wr_en) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == body_q - 1'b1) begin
            idx_d = '0;
            st_d  = keep_q ? S_CRC : S_TRL0;
          end
        end
      end
      S_CRC: begin
        wr_en    = 1'b1;
        wr_data  = crc_in[{idx_q[1:0], 3'b000} +: 8];
        in_ready = oddl_q && !have_q;
        if (in_ready && in_valid) begin
          last_d = in_data;
          have_d = 1'b1;
        end
        idx_d = idx_q + 1'b1;
        if (idx_q[1:0] == 2'd3) st_d = S_TRL0;
      end
      S_TRL0: begin
        if (oddl_q && !have_q) begin
          in_ready = 1'b1;
          wr_en    = in_valid;
          wr_data  = in_data;
        end else begin
          wr_en   = 1'b1;
          wr_data = oddl_q ? last_q : 8'h00;
        end
        if (wr_en) st_d = S_TRL1;
      end
      S_TRL1: begin
        wr_en   = 1'b1;
        wr_data = oddl_q ? CTRL_ODD : CTRL_EVEN;
        st_d    = S_FIN;
      end
      S_FIN: begin
        done = 1'b1;
        st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase

    if (wr_en) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;   len_q <= '0;    idx_q <= '0;
      status_q <= '0;   count_q <= '0;  body_q <= '0;
      oddl_q <= 1'b0;   keep_q <= 1'b0; page_q <= '0;
      addr_q <= '0;     last_q <= '0;   have_q <= 1'b0;
    end else begin
      st_q <= st_d;     len_q <= len_d;     idx_q <= idx_d;
      status_q <= status_d; count_q <= count_d; body_q <= body_d;
      oddl_q <= oddl_d; keep_q <= keep_d;   page_q <= page_d;
      addr_q <= addr_d; last_q <= last_d;   have_q <= have_d;
    end
  end

  assign wr_page = page_q;
  assign wr_addr = addr_q;

  // R1: a frame refused at acceptance never requests a page
  a_r1_refuse_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ready && frm_valid && plan.refuse) |=> !alloc_req);

  // R10: writes back to back always step the address by one
  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

  // R9: completion follows the write of a control byte
  a_r9_done_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && ($past(wr_data) == CTRL_ODD || $past(wr_data) == CTRL_EVEN)));

  // R11: no stream byte is taken while a descriptor can be accepted
  a_r11_idle_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> !in_ready);

  // R11: one outcome per frame per cycle
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, refused}));

endmodule

// File: rtl/rx_frame_formatter.sv
module rx_frame_formatter
  import rx_fmt_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGE_W     = 2,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518,
  localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rx_en,
  input  logic              cfg_soft_rst,
  input  logic              cfg_strip_crc,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [31:0]       crc_in,
  output logic              alloc_req,
  input  logic              alloc_ack,
  input  logic              alloc_ok,
  input  logic [PAGE_W-1:0] alloc_page,
  output logic              wr_en,
  output logic [PAGE_W-1:0] wr_page,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic              rxq_push,
  output logic [PAGE_W-1:0] rxq_page,
  output logic              rcv_irq,
  output logic              refused
);
  fmt_plan_t plan;

  rx_fmt_plan #(
    .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME),
    .PAGE_BYTES(PAGE_BYTES), .LONG_LIMIT(LONG_LIMIT)
  ) u_plan (
    .len(frm_len), .rx_en(cfg_rx_en), .soft_rst(cfg_soft_rst),
    .strip_crc(cfg_strip_crc), .plan(plan)
  );

  rx_fmt_engine #(.LEN_W(LEN_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_len(frm_len), .plan(plan),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .crc_in(crc_in),
    .alloc_req(alloc_req), .alloc_ack(alloc_ack), .alloc_ok(alloc_ok),
    .alloc_page(alloc_page),
    .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .refused(refused)
  );

  assign rxq_push = done;
  assign rcv_irq  = done;
  assign rxq_page = wr_page;

endmodule

// File: tb/sim_rx_frame_formatter.sv
module sim_rx_frame_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rx_en = 1'b1, cfg_soft_rst = 1'b0, cfg_strip_crc = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [11:0] frm_len = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic [31:0] crc_in = '0;
  logic        alloc_req, alloc_ack = 1'b0, alloc_ok = 1'b0;
  logic [1:0]  alloc_page = '0;
  logic        wr_en;
  logic [1:0]  wr_page;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;
  logic        done, rxq_push, rcv_irq, refused;
  logic [1:0]  rxq_page;

  rx_frame_formatter u0 (.*);

  always #5 clk = ~clk;

  int tot = 0, bad = 0, cyc = 0, first_cyc = 0;
  logic [7:0]  src_q[$];
  logic [31:0] exp_w[$];   // {page, addr, data}
  bit          exp_done = 0, exp_ref = 0, stall = 0, nostall = 0;
  int          exp_page = 0, exp_count = 0;
  logic [3:0]  pool_free = 4'hF;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  function automatic int lowest(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return 0;
  endfunction

  // driver and reference compare, one pass per clock, sampled 1 ns before the edge
  always begin
    @(negedge clk);
    if (src_q.size() > 0 && !(stall && ($urandom % 3 == 0))) begin
      in_valid = 1'b1; in_data = src_q[0];
    end else begin
      in_valid = 1'b0; in_data = 8'h00;
    end
    alloc_ack  = alloc_req && !(stall && ($urandom % 2 == 0));
    alloc_ok   = (pool_free != 0);
    alloc_page = 2'(lowest(pool_free));
    #4;
    cyc++;
    if (rst_n) begin
      if (wr_en) begin
        if (exp_w.size() == 0) chk(0, "R5", "unexpected write", wr_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_w.pop_front();
          if (e[23:8] == 16'd0) first_cyc = cyc;
          chk({wr_page, wr_addr, wr_data} == {e[25:24], e[18:8], e[7:0]}, "R3/R5/R6/R7",
              "write page/addr/data", {wr_page, wr_addr, wr_data}, {e[25:24], e[18:8], e[7:0]});
        end
      end
      if (refused) begin
        chk(exp_ref, "R1/R2/R8", "unexpected refusal", 1, 0);
        exp_ref = 0;
      end
      if (done) begin
        chk(exp_done && rxq_push && rcv_irq && rxq_page == 2'(exp_page) && exp_w.size() == 0,
            "R9", "completion page", rxq_page, exp_page);
        if (nostall) chk(cyc - first_cyc == exp_count, "R10", "cycles status->done",
                         cyc - first_cyc, exp_count);
        exp_done = 0;
      end
      if (frm_ready && in_ready) chk(0, "R11", "in_ready while idle", 1, 0);
      if (in_valid && in_ready) void'(src_q.pop_front());
      if (alloc_req && alloc_ack && alloc_ok) pool_free[alloc_page] = 1'b0;
    end
  end

  task automatic send(input int len, input bit st, input string tag);
    int even, body, cnt, stat, pg;
    bit oddl, refuse;
    logic [7:0] d[$];
    even = len & ~1;
    body = (len < 64) ? 64 : even;
    cnt  = body + 6 + (cfg_strip_crc ? 0 : 4);
    stat = ((len > 1518) ? 32'h0800 : 0) | ((len % 2) ? 32'h1000 : 0);
    oddl = (len % 2 == 1) && (len >= 64);
    refuse = !cfg_rx_en || cfg_soft_rst || cnt > 2048 || pool_free == 0;
    pg   = lowest(pool_free);
    crc_in = 32'hA1B2C3D4 ^ len;
    for (int k = 0; k < len; k++) src_q.push_back(8'((k * 13 + len * 7 + 5) & 255));
    if (refuse) exp_ref = 1;
    else begin
      d.push_back(8'(stat)); d.push_back(8'(stat >> 8));
      d.push_back(8'(cnt));  d.push_back(8'(cnt >> 8));
      for (int k = 0; k < body; k++) d.push_back((k < len) ? src_q[k] : 8'h00);
      if (!cfg_strip_crc) for (int k = 0; k < 4; k++) d.push_back(crc_in[8*k +: 8]);
      d.push_back(oddl ? src_q[len-1] : 8'h00);
      d.push_back(oddl ? 8'h60 : 8'h40);
      for (int k = 0; k < d.size(); k++) exp_w.push_back({6'd0, 2'(pg), 16'(k), d[k]});
      exp_done = 1; exp_page = pg; exp_count = cnt;
    end
    stall = st; nostall = !st;
    @(negedge clk); frm_valid = 1'b1; frm_len = 12'(len);
    #4; while (!frm_ready) begin @(negedge clk); #4; end
    @(negedge clk); frm_valid = 1'b0;
    while (exp_done || exp_ref || src_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_w.size() == 0 && src_q.size() == 0, tag, "frame fully handled",
        exp_w.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk(frm_ready && !in_ready && !alloc_req && !wr_en && !done && !refused, "R11",
        "reset state", {frm_ready, in_ready, alloc_req, wr_en, done}, 5'b10000);
    send(100, 0, "R5");   pool_free = 4'hF;   // even, CRC kept
    send(101, 0, "R7");   pool_free = 4'b1100; // odd long, last byte taken during CRC
    cfg_strip_crc = 1'b1;
    send(101, 0, "R6");   pool_free = 4'hF;   // odd long, taken in trailer
    cfg_strip_crc = 1'b0;
    send(30, 0, "R5");                         // even short
    cfg_strip_crc = 1'b1;
    send(31, 0, "R5");                         // odd short, padded
    send(0, 0, "R5");     pool_free = 4'hF;
    send(1519, 0, "R4");  pool_free = 4'hF;    // just over long limit
    send(1518, 0, "R4");  pool_free = 4'hF;
    send(2043, 0, "R2");  pool_free = 4'hF;    // count exactly 2048
    cfg_strip_crc = 1'b0;
    send(2039, 0, "R2");  pool_free = 4'hF;    // count exactly 2048 with CRC
    send(2040, 0, "R2");                       // count 2050, refused
    cfg_rx_en = 1'b0;
    send(70, 0, "R1");
    cfg_rx_en = 1'b1; cfg_soft_rst = 1'b1;
    send(70, 1, "R1");
    cfg_soft_rst = 1'b0; pool_free = 4'h0;
    send(80, 1, "R8");                         // no free page
    pool_free = 4'b1000;
    send(65, 1, "R11");   pool_free = 4'hF;
    send(63, 1, "R11");   pool_free = 4'hF;
    cfg_strip_crc = 1'b1;
    send(301, 1, "R11");  pool_free = 4'hF;
    send(64, 0, "R10");
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tot++; bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule